// File: doc/BRIEF.md
# Device Idle Power-State Controller

This block manages the power state of a single device. It treats the device as active in any cycle where a request is offered or the device reports itself busy. When activity stops, the block chooses whether to shut the device down using one of two policies, selected by `policy_i`:

- **Time-out policy.** Waits for a continuous idle interval before shutting down. That interval can be held at a programmed value or adjusted automatically from the lengths of past idle periods.
- **Predictive policy.** Shuts down at once when the busy period that just ended was short, and never shuts down after a long one.

Shutdown and wake-up each take a programmable number of cycles. During both, the device is unavailable and incoming requests are stalled through a ready-low handshake. A request that arrives while sleeping, or while a shutdown is in progress, starts a full wake-up. A shutdown that is under way is always allowed to finish first. Status outputs report:

- a two-bit power-state code;
- a one-cycle pulse on each entry to sleep;
- a saturating count of sleep episodes;
- the time-out value currently in force.

Top module: `pwr_mgr_top`

## Requirements
- R1: While reset is asserted and after its release, the state code is 0 (working), `req_ready_o` is 1, the sleep count is 0 and `tau_o` equals `tau_init_i`.
- R2: State codes are 0 working, 1 idle, 2 shutting down or sleeping, and 3 waking. `req_ready_o` is 1 only for codes 0 and 1, so a request offered in codes 2 or 3 is stalled.
- R3: In time-out mode (`policy_i`=0), let k be the last clock edge with activity. The state code is 1 after edges k+1 through k+tau and becomes 2 after edge k+tau+1. Activity in any idle cycle returns the block to working and restarts the interval.
- R4: In predictive mode (`policy_i`=1), a busy period of B active cycles with B < `theta_i` is followed by shutdown at the first inactive edge, with no idle wait.
- R5: In predictive mode, a busy period with B >= `theta_i` leaves the block in idle (code 1) for as long as no activity occurs.
- R6: `shutdown_o` is high for exactly `t_sd_i` cycles (a value of 0 acts as 1). The sleeping state follows immediately.
- R7: A request first sampled while sleeping raises `wakeup_o` for `t_wu_i` cycles (a value of 0 acts as 1). `req_ready_o` rises on the edge after that, so the ready signal appears `t_wu_i`+1 edges after the request is raised.
- R8: Activity during shutdown does not cut it short. When `t_sd_i` cycles have elapsed, the block goes straight into a full `t_wu_i`-cycle wake-up without waiting for a new request.
- R9: Each completed shutdown produces a one-cycle `sleep_pulse_o` in the first cycle after it and increments `sleep_count_o`. The count saturates at all ones.
- R10: With `adapt_en_i`=0, `tau_o` follows `tau_init_i`. With `adapt_en_i`=1 in time-out mode, the tau update happens when activity ends an idle period of L inactive edges (counted from the end of busy, through sleep, until the request). If L > 2*tau, tau becomes min(2*tau, `tau_max_i`). If L < tau, tau becomes max(tau/2, `tau_min_i`). Otherwise tau is unchanged.
- R11: The busy-length counter saturates rather than wrapping. In predictive mode with `theta_i` at the counter maximum, a busy period longer than that maximum is treated as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_i | input | 1 | 0 time-out, 1 predictive |
| adapt_en_i | input | 1 | Enable run-time tau adjustment |
| tau_init_i | input | CNT_W | Programmed tau value |
| tau_min_i | input | CNT_W | Lower clamp for adapted tau |
| tau_max_i | input | CNT_W | Upper clamp for adapted tau |
| theta_i | input | CNT_W | Busy-length threshold for predictive mode |
| t_sd_i | input | DLY_W | Shutdown delay in cycles |
| t_wu_i | input | DLY_W | Wake-up delay in cycles |
| req_valid_i | input | 1 | Request offered |
| dev_busy_i | input | 1 | Device reports busy |
| req_ready_o | output | 1 | Request accepted when high with valid |
| state_o | output | 2 | Power-state code |
| shutdown_o | output | 1 | Shutdown command in progress |
| wakeup_o | output | 1 | Wake-up command in progress |
| sleep_pulse_o | output | 1 | One cycle after each completed shutdown |
| sleep_count_o | output | SLP_W | Saturating sleep-episode count |
| tau_o | output | CNT_W | Time-out value in force |

## Verification
A corrupted state register or delay counter shows up as a state code, `shutdown_o` or `wakeup_o` window that is off by at least one cycle. The bench measures these windows edge by edge, so the fault is visible within one shutdown or wake-up episode. A wrong idle or busy counter moves the time-out edge or reverses a predictive decision on the next idle period. A wrong adaptation rule shows up in `tau_o` on the very edge that accepts the request ending the idle period.

// File: rtl/pwr_mgr_pkg.sv
package pwr_mgr_pkg;
  typedef enum logic [2:0] {
    ST_WORK,
    ST_IDLE,
    ST_SHUT,
    ST_SLEEP,
    ST_WAKE
  } pm_state_e;

  localparam logic POL_TIMEOUT = 1'b0;
  localparam logic POL_PREDICT = 1'b1;

  function automatic logic [1:0] state_code(pm_state_e s);
    case (s)
      ST_WORK:  return 2'd0;
      ST_IDLE:  return 2'd1;
      ST_WAKE:  return 2'd3;
      default:  return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/pwr_sat_cnt.sv
module pwr_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  // clear and increment together load 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (clr_i)             q_o <= W'(inc_i);
    else if (inc_i && !(&q_o))  q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/pwr_tau_adapt.sv
module pwr_tau_adapt #(
  parameter int W = 16
) (
  input  logic [W-1:0] tau_i,
  input  logic [W-1:0] idle_len_i,
  input  logic [W-1:0] tau_min_i,
  input  logic [W-1:0] tau_max_i,
  output logic [W-1:0] tau_nxt_o
);
  logic [W:0]   dbl;
  logic [W-1:0] half;

  assign dbl  = {tau_i, 1'b0};
  assign half = tau_i >> 1;

  always_comb begin
    if ({1'b0, idle_len_i} > dbl)
      tau_nxt_o = (dbl > {1'b0, tau_max_i}) ? tau_max_i : dbl[W-1:0];
    else if (idle_len_i < tau_i)
      tau_nxt_o = (half < tau_min_i) ? tau_min_i : half;
    else
      tau_nxt_o = tau_i;
  end
endmodule

// File: rtl/pwr_mgr_top.sv
module pwr_mgr_top
  import pwr_mgr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 16,
  parameter int SLP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             policy_i,
  input  logic             adapt_en_i,
  input  logic [CNT_W-1:0] tau_init_i,
  input  logic [CNT_W-1:0] tau_min_i,
  input  logic [CNT_W-1:0] tau_max_i,
  input  logic [CNT_W-1:0] theta_i,
  input  logic [DLY_W-1:0] t_sd_i,
  input  logic [DLY_W-1:0] t_wu_i,
  input  logic             req_valid_i,
  input  logic             dev_busy_i,
  output logic             req_ready_o,
  output logic [1:0]       state_o,
  output logic             shutdown_o,
  output logic             wakeup_o,
  output logic             sleep_pulse_o,
  output logic [SLP_W-1:0] sleep_count_o,
  output logic [CNT_W-1:0] tau_o
);
  localparam int DW1 = DLY_W + 1;

  pm_state_e        st_q, st_d;
  logic             act, pend_q, pulse_q, go_sleep, upd;
  logic             tau_own_q;
  logic [CNT_W-1:0] tau_q, tau_eff, tau_nxt;
  logic [CNT_W-1:0] busy_q, idle_q;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W:0]   dly_nx;
  logic             sd_done, wu_done, st_chg;

  assign act     = req_valid_i | dev_busy_i;
  assign dly_nx  = {1'b0, dly_q} + DW1'(1);
  assign sd_done = dly_nx >= {1'b0, t_sd_i};
  assign wu_done = dly_nx >= {1'b0, t_wu_i};
  assign st_chg  = (st_d != st_q);
  assign tau_eff = tau_own_q ? tau_q : tau_init_i;

  always_comb begin
    st_d     = st_q;
    go_sleep = 1'b0;
    upd      = 1'b0;
    case (st_q)
      ST_WORK: if (!act) begin
        if (policy_i == POL_PREDICT && busy_q < theta_i) st_d = ST_SHUT;
        else                                             st_d = ST_IDLE;
      end
      ST_IDLE: if (act) begin
        st_d = ST_WORK;
        upd  = 1'b1;
      end else if (policy_i == POL_TIMEOUT && idle_q >= tau_eff) begin
        st_d = ST_SHUT;
      end
      ST_SHUT: if (sd_done) begin
        go_sleep = 1'b1;
        if (pend_q || act) begin
          st_d = ST_WAKE;
          upd  = 1'b1;
        end else begin
          st_d = ST_SLEEP;
        end
      end
      ST_SLEEP: if (act) begin
        st_d = ST_WAKE;
        upd  = 1'b1;
      end
      ST_WAKE: if (wu_done) st_d = ST_WORK;
      default: st_d = ST_WORK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_WORK;
      pend_q    <= 1'b0;
      pulse_q   <= 1'b0;
      tau_own_q <= 1'b0;
      tau_q     <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= (st_q == ST_SHUT) && (st_d == ST_SHUT) && (pend_q || act);
      pulse_q <= go_sleep;
      if (!adapt_en_i) begin
        tau_own_q <= 1'b0;
      end else if (upd && policy_i == POL_TIMEOUT) begin
        tau_own_q <= 1'b1;
        tau_q     <= tau_nxt;
      end
    end
  end

  pwr_sat_cnt #(.W(CNT_W)) u_busy_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i ((st_q == ST_IDLE) || (st_q == ST_WAKE)),
    .inc_i (act && ((st_q == ST_WORK) || (st_q == ST_IDLE))),
    .q_o   (busy_q)
  );

  // counts inactive edges from end of busy until the next request
  pwr_sat_cnt #(.W(CNT_W)) u_idle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == ST_WORK),
    .inc_i (!act && !pend_q && (st_q != ST_WAKE)),
    .q_o   (idle_q)
  );

  pwr_sat_cnt #(.W(DLY_W)) u_dly_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_chg),
    .inc_i (!st_chg),
    .q_o   (dly_q)
  );

  pwr_sat_cnt #(.W(SLP_W)) u_sleep_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (1'b0),
    .inc_i (go_sleep),
    .q_o   (sleep_count_o)
  );

  pwr_tau_adapt #(.W(CNT_W)) u_tau (
    .tau_i     (tau_eff),
    .idle_len_i(idle_q),
    .tau_min_i (tau_min_i),
    .tau_max_i (tau_max_i),
    .tau_nxt_o (tau_nxt)
  );

  assign state_o       = state_code(st_q);
  assign req_ready_o   = (st_q == ST_WORK) || (st_q == ST_IDLE);
  assign shutdown_o    = (st_q == ST_SHUT);
  assign wakeup_o      = (st_q == ST_WAKE);
  assign sleep_pulse_o = pulse_q;
  assign tau_o         = tau_eff;
endmodule

// File: rtl/pwr_mgr_chk.sv
module pwr_mgr_chk #(
  parameter int CNT_W = 16,
  parameter int SLP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             policy_i,
  input logic             adapt_en_i,
  input logic [CNT_W-1:0] tau_init_i,
  input logic [CNT_W-1:0] tau_min_i,
  input logic [CNT_W-1:0] tau_max_i,
  input logic             req_ready_o,
  input logic [1:0]       state_o,
  input logic             shutdown_o,
  input logic             wakeup_o,
  input logic             sleep_pulse_o,
  input logic [SLP_W-1:0] sleep_count_o,
  input logic [CNT_W-1:0] tau_o
);
  p_ready_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[1] |-> !req_ready_o);

  p_direct_shut_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && $past(state_o) == 2'd0) |-> $past(policy_i));

  p_shut_to_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shutdown_o) |-> sleep_pulse_o);

  p_wake_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wakeup_o) |-> $past(state_o) == 2'd2);

  p_pulse_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_pulse_o |=> !sleep_pulse_o);

  p_count_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_pulse_o |-> (sleep_count_o == SLP_W'($past(sleep_count_o) + 1'b1))
                      || (&sleep_count_o));

  p_count_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_pulse_o |-> $stable(sleep_count_o));

  p_tau_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adapt_en_i && $past(adapt_en_i) && !$stable(tau_o) && $stable(tau_init_i)
     && $stable(tau_min_i) && $stable(tau_max_i))
    |-> (tau_o >= tau_min_i && tau_o <= tau_max_i));
endmodule

bind pwr_mgr_top pwr_mgr_chk #(.CNT_W(CNT_W), .SLP_W(SLP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .adapt_en_i   (adapt_en_i),
  .tau_init_i   (tau_init_i),
  .tau_min_i    (tau_min_i),
  .tau_max_i    (tau_max_i),
  .req_ready_o  (req_ready_o),
  .state_o      (state_o),
  .shutdown_o   (shutdown_o),
  .wakeup_o     (wakeup_o),
  .sleep_pulse_o(sleep_pulse_o),
  .sleep_count_o(sleep_count_o),
  .tau_o        (tau_o)
);

// File: tb/pwr_mgr_top_tb.sv
module pwr_mgr_top_tb;
  localparam int CNT_W = 8;
  localparam int DLY_W = 4;
  localparam int SLP_W = 3;
  localparam int SMAX  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pol = 1'b0, adapt = 1'b0;
  logic [CNT_W-1:0] tau_init = 8'd200, tau_min = 8'd2, tau_max = 8'd16, theta = 8'd5;
  logic [DLY_W-1:0] tsd = 4'd1, twu = 4'd1;
  logic             req_v = 1'b0, dev_b = 1'b0;
  logic             ready, sd, wu, pulse;
  logic [1:0]       st;
  logic [SLP_W-1:0] scnt;
  logic [CNT_W-1:0] tau_o;

  int checks = 0, fails = 0, nsleep = 0;

  always #2.5 clk = ~clk;

  pwr_mgr_top #(.CNT_W(CNT_W), .DLY_W(DLY_W), .SLP_W(SLP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .adapt_en_i(adapt),
    .tau_init_i(tau_init), .tau_min_i(tau_min), .tau_max_i(tau_max),
    .theta_i(theta), .t_sd_i(tsd), .t_wu_i(twu),
    .req_valid_i(req_v), .dev_busy_i(dev_b), .req_ready_o(ready),
    .state_o(st), .shutdown_o(sd), .wakeup_o(wu), .sleep_pulse_o(pulse),
    .sleep_count_o(scnt), .tau_o(tau_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_req();
    int g;
    req_v = 1'b1;
    g = 0;
    while (!ready && g < 500) begin tick(); g++; end
    tick();
    req_v = 1'b0;
  endtask

  task automatic wait_code(input int code, output int n);
    n = 0;
    while (int'(st) != code && n < 1000) begin tick(); n++; end
  endtask

  task automatic finish_shut();
    int g;
    g = 0;
    while (sd && g < 100) begin tick(); g++; end
    nsleep++;
    check("R9 count", int'(scnt), (nsleep > SMAX) ? SMAX : nsleep);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int n, m, w;
    #1;
    // R1 during and after reset
    tick();
    check("R1 state", int'(st), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 count", int'(scnt), 0);
    check("R1 tau", int'(tau_o), 200);
    rst_n = 1'b1;
    tick();
    check("R1 tau after release", int'(tau_o), 200);
    check("R1 count after release", int'(scnt), 0);

    // timeout sweep: R3 R6 R7 R9 R2
    for (int ta = 1; ta <= 4; ta++) begin
      for (int s = 1; s <= 3; s++) begin
        for (int u = 1; u <= 3; u++) begin
          tau_init = CNT_W'(ta);
          tsd = DLY_W'(s);
          twu = DLY_W'(u);
          do_req();
          wait_code(2, n);
          check("R3 timeout edge", n, ta + 1);
          check("R2 ready low", int'(ready), 0);
          m = 0;
          while (sd && m < 50) begin
            check("R2 ready low in shutdown", int'(ready), 0);
            m++;
            tick();
          end
          check("R6 shutdown length", m, s);
          check("R9 pulse", int'(pulse), 1);
          check("R6 sleeping", int'(st), 2);
          nsleep++;
          check("R9 count", int'(scnt), (nsleep > SMAX) ? SMAX : nsleep);
          req_v = 1'b1;
          tick();
          check("R9 pulse single", int'(pulse), 0);
          check("R7 wakeup", int'(wu), 1);
          w = 1;
          while (!ready && w < 50) begin tick(); w++; end
          check("R7 wake latency", w, u + 1);
          tick();
          req_v = 1'b0;
        end
      end
    end

    // R3 cancel by activity
    tau_init = 8'd6; tsd = 4'd2; twu = 4'd1;
    do_req();
    repeat (3) tick();
    check("R3 idle before cancel", int'(st), 1);
    dev_b = 1'b1;
    tick();
    dev_b = 1'b0;
    check("R3 cancelled", int'(st), 0);
    wait_code(2, n);
    check("R3 restarted interval", n, 7);
    finish_shut();

    // R8 request during shutdown
    tau_init = 8'd2; tsd = 4'd4; twu = 4'd3;
    do_req();
    wait_code(2, n);
    req_v = 1'b1;
    m = 0;
    while (sd && m < 50) begin m++; tick(); end
    check("R8 shutdown completes", m, 4);
    check("R8 pulse", int'(pulse), 1);
    check("R8 straight to wake", int'(st), 3);
    nsleep++;
    check("R9 count", int'(scnt), (nsleep > SMAX) ? SMAX : nsleep);
    w = 0;
    while (wu && w < 50) begin w++; tick(); end
    check("R8 full wake", w, 3);
    check("R8 ready", int'(ready), 1);
    tick();
    req_v = 1'b0;

    // predictive: R4 R5
    pol = 1'b1; theta = 8'd0; tsd = 4'd2; twu = 4'd1;
    tick(); tick();
    theta = 8'd5;
    for (int b = 1; b <= 8; b++) begin
      do_req();
      if (b > 1) begin
        dev_b = 1'b1;
        repeat (b - 1) tick();
        dev_b = 1'b0;
      end
      tick();
      if (b < 5) begin
        check("R4 immediate shut", int'(st), 2);
        finish_shut();
      end else begin
        check("R5 no shut", int'(st), 1);
        repeat (20) tick();
        check("R5 stays idle", int'(st), 1);
      end
    end

    // R11 busy counter saturation
    theta = 8'd255;
    do_req();
    dev_b = 1'b1;
    repeat (299) tick();
    dev_b = 1'b0;
    tick();
    check("R11 long busy saturates", int'(st), 1);
    repeat (10) tick();
    check("R11 stays idle", int'(st), 1);
    do_req();
    dev_b = 1'b1;
    repeat (253) tick();
    dev_b = 1'b0;
    tick();
    check("R11 below threshold shuts", int'(st), 2);
    finish_shut();

    // R10 fixed and adaptive tau
    pol = 1'b0; adapt = 1'b0; tau_init = 8'd9;
    tick();
    check("R10 fixed follows input", int'(tau_o), 9);
    tau_init = 8'd4; tau_min = 8'd2; tau_max = 8'd16; tsd = 4'd2; twu = 4'd1;
    do_req();
    adapt = 1'b1;
    begin
      int len [9] = '{12, 5, 3, 1, 20, 20, 20, 40, 20};
      int exp [9] = '{8, 4, 2, 2, 4, 8, 16, 16, 16};
      for (int i = 0; i < 9; i++) begin
        repeat (len[i]) tick();
        do_req();
        check("R10 adapted tau", int'(tau_o), exp[i]);
      end
    end
    adapt = 1'b0;
    tick();
    check("R10 fixed after adapt", int'(tau_o), 4);

    summary();
  end
endmodule